// File: doc/BRIEF.md
# Dual-Issue Instruction Word Sequencer

This block sits between instruction fetch and the execution units of a small very-long-word core. Each fetched 32-bit word holds either one long instruction or two 15-bit short instructions. The two short instructions run in a fixed order, either left first or right first, or they are presented together for parallel issue. The sequencer reads the format field and sends each sub-instruction to execution with a dispatch strobe, a payload and a side tag. It then waits for the execution unit to return completion, branch and exception information.

After every word the sequencer works out the next program counter. A branch reported by execution redirects it. A zero-overhead repeat block can fold a jump back to the loop start into the update. Otherwise the counter advances by one word. When the first of two ordered sub-instructions takes a branch, the second one is squashed. A group of free-running counters records cycles, word formats, squashed slots and parallel no-operations. The sequencer can run words back to back, or stop after each word in single-step mode. An exception freezes it until reset.

Top module: `iw_sequencer`

## Requirements
- R1: When bits [31:30] of a fetched word are 11, exactly one dispatch is made: `disp_vld` with `disp_long`=1, and `disp_a` carries bits [29:0].
- R2: The left short instruction is bits [29:15] and the right one is bits [14:0]. Format 01 dispatches left and then right. Format 10 dispatches right and then left. Each dispatch uses `disp_vld` with `disp_long`=0, `disp_right` (0 = left, 1 = right) and the 15-bit payload in `disp_a[14:0]`.
- R3: Format 00 makes a single `disp_par` strobe, with the left instruction in `disp_a[14:0]` and the right one in `disp_b`. `disp_vld` and `disp_par` are never high together.
- R4: In formats 01 and 10, if the first sub-instruction reports a jump and no exception, the second one is not dispatched, the PC takes the jump target and `cnt_jskip` increments.
- R5: `cnt_cycles` increments once per fetched word and once more for each second ordered sub-instruction that is dispatched.
- R6: `cnt_lr`, `cnt_rl` and `cnt_long` count words of formats 01, 10 and 11.
- R7: A format-00 word whose left or right instruction equals the no-operation code (default 15'h2F00) does not increment `cnt_par`. Instead, a no-operation in the left slot increments `cnt_nop_l` and one in the right slot increments `cnt_nop_r`. A format-00 word with no no-operation increments `cnt_par`.
- R8: `rpt_wr` while halted loads the loop start, loop end and count, and sets `rpt_active` when the count is nonzero. When a word completes while the loop is active and the post-branch PC equals the loop end, the count decrements. If it reaches zero, `rpt_active` clears and the normal update applies. Otherwise the PC loads the loop start.
- R9: If neither a jump nor a loop reload changed the PC during a word, the PC advances by one. A jump, including one from the second ordered slot or from a parallel word, loads the reported target.
- R10: An exception reported with `exec_done` stops sequencing. `exc_held` rises and stays high until reset, the PC keeps its value, and no later fetch or dispatch happens even when `go` is pulsed.
- R11: With `step_mode`=1 the sequencer returns to halted after each word. With `step_mode`=0 it fetches the next word without halting.
- R12: After reset the sequencer is halted with the PC at `RESET_PC`, all counters at zero, `rpt_active` low and no fetch request.

Port widths below use the default parameters PCW=16, CNTW=32 and RCW=16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Leave the halted state and start fetching |
| step_mode | input | 1 | Halt after each word when high |
| fetch_req | output | 1 | Requests the word at `fetch_pc` |
| fetch_pc | output | PCW | Word address of the current word |
| fetch_valid | input | 1 | `fetch_word` is valid for the request |
| fetch_word | input | 32 | Fetched instruction word |
| disp_vld | output | 1 | Single dispatch strobe (one short or one long instruction) |
| disp_par | output | 1 | Dual dispatch strobe for parallel issue |
| disp_long | output | 1 | The single dispatch is a long instruction |
| disp_right | output | 1 | Side of a single short dispatch (1 = right) |
| disp_a | output | 30 | Long payload, short payload, or left payload of a parallel pair |
| disp_b | output | 15 | Right payload of a parallel pair |
| exec_done | input | 1 | Execution finished the last dispatch |
| exec_jump | input | 1 | The finished dispatch changed the PC |
| exec_target | input | PCW | New PC when `exec_jump` is high |
| exec_exc | input | 1 | The finished dispatch raised an exception |
| rpt_wr | input | 1 | Load repeat-loop settings (accepted while halted) |
| rpt_start | input | PCW | Loop start address |
| rpt_end | input | PCW | Loop end address |
| rpt_count | input | RCW | Loop iteration count |
| rpt_active | output | 1 | Repeat loop armed |
| halted | output | 1 | Sequencer idle, waiting for `go` |
| exc_held | output | 1 | Sequencer stopped by an exception |
| cnt_cycles | output | CNTW | Cycle counter |
| cnt_par | output | CNTW | Parallel words without no-operation |
| cnt_lr | output | CNTW | Left-then-right words |
| cnt_rl | output | CNTW | Right-then-left words |
| cnt_long | output | CNTW | Long words |
| cnt_jskip | output | CNTW | Second slots squashed by a jump |
| cnt_nop_l | output | CNTW | Left no-operations in parallel words |
| cnt_nop_r | output | CNTW | Right no-operations in parallel words |

## Verification
The assertions assume that `exec_done` only arrives after a dispatch strobe and is a single-cycle pulse. They also assume that `fetch_valid` is given only while `fetch_req` is high. The stimulus keeps to this by answering each strobe with exactly one completion pulse, and by driving `fetch_valid` only in the cycle where it sees the request. Loop settings are written only while the sequencer is halted, and jump targets never wrap the PC.

// File: rtl/iw_pkg.sv
package iw_pkg;
  typedef enum logic [1:0] {
    FMT_PAR  = 2'b00,
    FMT_LR   = 2'b01,
    FMT_RL   = 2'b10,
    FMT_LONG = 2'b11
  } fmt_e;

  typedef enum logic [2:0] {
    ST_HALT, ST_FETCH, ST_WAIT1, ST_WAIT2, ST_UPD, ST_EXC
  } st_e;

  localparam int NCNT   = 8;
  localparam int C_CYC  = 0;
  localparam int C_PAR  = 1;
  localparam int C_LR   = 2;
  localparam int C_RL   = 3;
  localparam int C_LONG = 4;
  localparam int C_JSK  = 5;
  localparam int C_NOPL = 6;
  localparam int C_NOPR = 7;
endpackage

// File: rtl/iw_decode.sv
module iw_decode
  import iw_pkg::*;
#(
  parameter logic [14:0] NOP_SHORT = 15'h2F00
) (
  input  logic [31:0] word,
  output fmt_e        fmt,
  output logic [14:0] left,
  output logic [14:0] right,
  output logic [14:0] first,
  output logic [14:0] second,
  output logic        first_right,
  output logic        seq,
  output logic        nop_l,
  output logic        nop_r,
  output logic [29:0] long_pl
);
  always_comb begin
    fmt         = fmt_e'(word[31:30]);
    left        = word[29:15];
    right       = word[14:0];
    long_pl     = word[29:0];
    first_right = (fmt == FMT_RL);
    seq         = (fmt == FMT_LR) || (fmt == FMT_RL);
    first       = first_right ? right : left;
    second      = first_right ? left : right;
    nop_l       = (left == NOP_SHORT);
    nop_r       = (right == NOP_SHORT);
  end
endmodule

// File: rtl/iw_stats.sv
module iw_stats #(
  parameter int N    = 8,
  parameter int CNTW = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N-1:0]            inc,
  output logic [N-1:0][CNTW-1:0]  cnt
);
  for (genvar i = 0; i < N; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)         cnt[i] <= '0;
      else if (inc[i]) cnt[i] <= cnt[i] + 1'b1;
    end

    p_cnt_step_r5: assert property (@(posedge clk) disable iff (rst)
      (cnt[i] == $past(cnt[i])) || (cnt[i] == $past(cnt[i]) + 1'b1));
  end
endmodule

// File: rtl/iw_repeat.sv
module iw_repeat #(
  parameter int PCW = 16,
  parameter int RCW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic [PCW-1:0] cfg_start,
  input  logic [PCW-1:0] cfg_end,
  input  logic [RCW-1:0] cfg_cnt,
  input  logic           upd,
  input  logic [PCW-1:0] pc_cur,
  input  logic           changed,
  input  logic [PCW-1:0] target,
  output logic [PCW-1:0] pc_next,
  output logic           active
);
  logic [PCW-1:0] lp_start, lp_end, p_post;
  logic [RCW-1:0] remain;
  logic           hit, last, reload;

  always_comb begin
    p_post  = changed ? target : pc_cur;
    hit     = active && (p_post == lp_end);
    last    = (remain == {{(RCW-1){1'b0}}, 1'b1});
    reload  = hit && !last;
    if (reload)       pc_next = lp_start;
    else if (changed) pc_next = target;
    else              pc_next = pc_cur + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lp_start <= '0;
      lp_end   <= '0;
      remain   <= '0;
      active   <= 1'b0;
    end else if (cfg_wr) begin
      lp_start <= cfg_start;
      lp_end   <= cfg_end;
      remain   <= cfg_cnt;
      active   <= (cfg_cnt != '0);
    end else if (upd && hit) begin
      remain <= remain - 1'b1;
      if (last) active <= 1'b0;
    end
  end

  p_loop_ends_on_update_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> $past(upd));
  p_active_has_count_r8: assert property (@(posedge clk) disable iff (rst)
    active |-> (remain != '0));
endmodule

// File: rtl/iw_sequencer.sv
module iw_sequencer
  import iw_pkg::*;
#(
  parameter int             PCW       = 16,
  parameter int             CNTW      = 32,
  parameter int             RCW       = 16,
  parameter logic [PCW-1:0] RESET_PC  = '0,
  parameter logic [14:0]    NOP_SHORT = 15'h2F00
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic            step_mode,
  output logic            fetch_req,
  output logic [PCW-1:0]  fetch_pc,
  input  logic            fetch_valid,
  input  logic [31:0]     fetch_word,
  output logic            disp_vld,
  output logic            disp_par,
  output logic            disp_long,
  output logic            disp_right,
  output logic [29:0]     disp_a,
  output logic [14:0]     disp_b,
  input  logic            exec_done,
  input  logic            exec_jump,
  input  logic [PCW-1:0]  exec_target,
  input  logic            exec_exc,
  input  logic            rpt_wr,
  input  logic [PCW-1:0]  rpt_start,
  input  logic [PCW-1:0]  rpt_end,
  input  logic [RCW-1:0]  rpt_count,
  output logic            rpt_active,
  output logic            halted,
  output logic            exc_held,
  output logic [CNTW-1:0] cnt_cycles,
  output logic [CNTW-1:0] cnt_par,
  output logic [CNTW-1:0] cnt_lr,
  output logic [CNTW-1:0] cnt_rl,
  output logic [CNTW-1:0] cnt_long,
  output logic [CNTW-1:0] cnt_jskip,
  output logic [CNTW-1:0] cnt_nop_l,
  output logic [CNTW-1:0] cnt_nop_r
);
  st_e            st;
  logic [PCW-1:0] pc_q, tgt_q, pc_next;
  logic [31:0]    word_q, dec_in;
  logic           chg_q;

  fmt_e        d_fmt;
  logic [14:0] d_left, d_right, d_first, d_second;
  logic        d_first_right, d_seq, d_nop_l, d_nop_r;
  logic [29:0] d_long;

  logic                        acc_fetch, w1_done, go_second, squash;
  logic [NCNT-1:0]             inc;
  logic [NCNT-1:0][CNTW-1:0]   cnt_all;

  assign dec_in = (st == ST_FETCH) ? fetch_word : word_q;

  iw_decode #(.NOP_SHORT(NOP_SHORT)) u_dec (
    .word(dec_in), .fmt(d_fmt), .left(d_left), .right(d_right),
    .first(d_first), .second(d_second), .first_right(d_first_right),
    .seq(d_seq), .nop_l(d_nop_l), .nop_r(d_nop_r), .long_pl(d_long)
  );

  iw_repeat #(.PCW(PCW), .RCW(RCW)) u_rpt (
    .clk(clk), .rst(rst),
    .cfg_wr(rpt_wr && (st == ST_HALT)),
    .cfg_start(rpt_start), .cfg_end(rpt_end), .cfg_cnt(rpt_count),
    .upd(st == ST_UPD), .pc_cur(pc_q), .changed(chg_q), .target(tgt_q),
    .pc_next(pc_next), .active(rpt_active)
  );

  always_comb begin
    acc_fetch = (st == ST_FETCH) && fetch_valid;
    w1_done   = (st == ST_WAIT1) && exec_done && !exec_exc;
    go_second = w1_done && d_seq && !exec_jump;
    squash    = w1_done && d_seq && exec_jump;
    inc          = '0;
    inc[C_CYC]   = acc_fetch || go_second;
    inc[C_PAR]   = acc_fetch && (d_fmt == FMT_PAR) && !d_nop_l && !d_nop_r;
    inc[C_LR]    = acc_fetch && (d_fmt == FMT_LR);
    inc[C_RL]    = acc_fetch && (d_fmt == FMT_RL);
    inc[C_LONG]  = acc_fetch && (d_fmt == FMT_LONG);
    inc[C_JSK]   = squash;
    inc[C_NOPL]  = acc_fetch && (d_fmt == FMT_PAR) && d_nop_l;
    inc[C_NOPR]  = acc_fetch && (d_fmt == FMT_PAR) && d_nop_r;
  end

  iw_stats #(.N(NCNT), .CNTW(CNTW)) u_stats (
    .clk(clk), .rst(rst), .inc(inc), .cnt(cnt_all)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_HALT;
      pc_q       <= RESET_PC;
      word_q     <= '0;
      chg_q      <= 1'b0;
      tgt_q      <= '0;
      disp_vld   <= 1'b0;
      disp_par   <= 1'b0;
      disp_long  <= 1'b0;
      disp_right <= 1'b0;
      disp_a     <= '0;
      disp_b     <= '0;
    end else begin
      disp_vld <= 1'b0;
      disp_par <= 1'b0;
      unique case (st)
        ST_HALT: if (go) st <= ST_FETCH;
        ST_FETCH: if (fetch_valid) begin
          word_q <= fetch_word;
          chg_q  <= 1'b0;
          st     <= ST_WAIT1;
          if (d_fmt == FMT_PAR) begin
            disp_par <= 1'b1;
            disp_a   <= {15'd0, d_left};
            disp_b   <= d_right;
          end else if (d_fmt == FMT_LONG) begin
            disp_vld  <= 1'b1;
            disp_long <= 1'b1;
            disp_a    <= d_long;
          end else begin
            disp_vld   <= 1'b1;
            disp_long  <= 1'b0;
            disp_right <= d_first_right;
            disp_a     <= {15'd0, d_first};
          end
        end
        ST_WAIT1: if (exec_done) begin
          if (exec_exc) st <= ST_EXC;
          else begin
            chg_q <= exec_jump;
            tgt_q <= exec_target;
            if (go_second) begin
              disp_vld   <= 1'b1;
              disp_long  <= 1'b0;
              disp_right <= !d_first_right;
              disp_a     <= {15'd0, d_second};
              st         <= ST_WAIT2;
            end else st <= ST_UPD;
          end
        end
        ST_WAIT2: if (exec_done) begin
          if (exec_exc) st <= ST_EXC;
          else begin
            if (exec_jump) begin
              chg_q <= 1'b1;
              tgt_q <= exec_target;
            end
            st <= ST_UPD;
          end
        end
        ST_UPD: begin
          pc_q <= pc_next;
          st   <= step_mode ? ST_HALT : ST_FETCH;
        end
        default: st <= ST_EXC;
      endcase
    end
  end

  assign fetch_req  = (st == ST_FETCH);
  assign fetch_pc   = pc_q;
  assign halted     = (st == ST_HALT);
  assign exc_held   = (st == ST_EXC);
  assign cnt_cycles = cnt_all[C_CYC];
  assign cnt_par    = cnt_all[C_PAR];
  assign cnt_lr     = cnt_all[C_LR];
  assign cnt_rl     = cnt_all[C_RL];
  assign cnt_long   = cnt_all[C_LONG];
  assign cnt_jskip  = cnt_all[C_JSK];
  assign cnt_nop_l  = cnt_all[C_NOPL];
  assign cnt_nop_r  = cnt_all[C_NOPR];

  p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({disp_vld, disp_par}));
  p_exc_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    exc_held |=> exc_held);
  p_exc_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    exc_held |-> (!fetch_req && !disp_vld && !disp_par));
  p_exc_pc_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (exc_held && $past(exc_held)) |-> $stable(fetch_pc));
  p_squash_r4: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_WAIT1) && exec_done && exec_jump) |=> !disp_vld);
  p_pc_inc_r9: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_UPD) && !chg_q && !rpt_active) |=> (fetch_pc == $past(fetch_pc) + 1'b1));
  p_step_halt_r11: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_UPD) && step_mode) |=> halted);
endmodule

// File: tb/sim_iw_sequencer.sv
`timescale 1ns/1ps
module sim_iw_sequencer;
  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic go = 0, step_mode = 1;
  logic fetch_req, fetch_valid = 0;
  logic [15:0] fetch_pc;
  logic [31:0] fetch_word = '0;
  logic disp_vld, disp_par, disp_long, disp_right;
  logic [29:0] disp_a;
  logic [14:0] disp_b;
  logic exec_done = 0, exec_jump = 0, exec_exc = 0;
  logic [15:0] exec_target = '0;
  logic rpt_wr = 0;
  logic [15:0] rpt_start = '0, rpt_end = '0, rpt_count = '0;
  logic rpt_active, halted, exc_held;
  logic [31:0] cnt_cycles, cnt_par, cnt_lr, cnt_rl, cnt_long, cnt_jskip, cnt_nop_l, cnt_nop_r;

  iw_sequencer u0 (.*);

  int checks = 0, fails = 0, cyc = 0;

  // stimulus queues and dispatch log for one serve() run
  logic [31:0] q_word [8];
  logic        q_j [8];
  logic [15:0] q_t [8];
  logic        q_x [8];
  logic        lg_long [8], lg_right [8], lg_par [8];
  logic [29:0] lg_a [8];
  logic [14:0] lg_b [8];
  int nfetch, ndisp;

  // {word, jump1, target1, jump2, target2, expected pc, expected dispatches}
  localparam logic [83:0] TBL [7] = '{
    {32'hC0000123,                1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0001, 2'd1},
    {2'b01, 15'h1234, 15'h0567,   1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0002, 2'd2},
    {2'b10, 15'h0ABC, 15'h1DEF,   1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0003, 2'd2},
    {2'b01, 15'h0111, 15'h0222,   1'b1, 16'h0040, 1'b0, 16'h0000, 16'h0040, 2'd1},
    {2'b00, 15'h0333, 15'h0444,   1'b1, 16'h0050, 1'b0, 16'h0000, 16'h0050, 2'd1},
    {2'b00, 15'h2F00, 15'h0555,   1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0051, 2'd1},
    {2'b10, 15'h0666, 15'h0777,   1'b0, 16'h0000, 1'b1, 16'h0010, 16'h0010, 2'd2}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_q();
    for (int i = 0; i < 8; i++) begin
      q_word[i] = '0; q_j[i] = 0; q_t[i] = '0; q_x[i] = 0;
    end
  endtask

  // pulses go, then serves fetches and answers dispatches until halt or exception
  task automatic serve();
    bit started = 0;
    nfetch = 0; ndisp = 0;
    @(negedge clk); go = 1;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      go = 0; fetch_valid = 0; exec_done = 0; exec_jump = 0; exec_exc = 0;
      if (!halted) started = 1;
      if (started && (halted || exc_held)) break;
      if (fetch_req && nfetch < 8) begin
        fetch_valid = 1; fetch_word = q_word[nfetch]; nfetch++;
      end
      if ((disp_vld || disp_par) && ndisp < 8) begin
        lg_long[ndisp] = disp_long; lg_right[ndisp] = disp_right;
        lg_par[ndisp] = disp_par; lg_a[ndisp] = disp_a; lg_b[ndisp] = disp_b;
        exec_done = 1; exec_jump = q_j[ndisp];
        exec_target = q_t[ndisp]; exec_exc = q_x[ndisp];
        ndisp++;
      end
    end
  endtask

  task automatic long_word(input bit j, input logic [15:0] t);
    clear_q();
    q_word[0] = 32'hC0000000 | 32'h0000_0ABC; q_j[0] = j; q_t[0] = t;
    serve();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk(halted && !fetch_req && !rpt_active, "R12 idle", {halted, fetch_req, rpt_active}, 3'b100);
    chk(fetch_pc == 16'h0, "R12 pc", fetch_pc, 0);
    chk((cnt_cycles | cnt_par | cnt_long | cnt_jskip) == 0, "R12 counters", cnt_cycles, 0);

    // table-driven single-step words
    for (int e = 0; e < 7; e++) begin
      logic [31:0] w;
      w = TBL[e][83:52];
      clear_q();
      q_word[0] = w;
      q_j[0] = TBL[e][51]; q_t[0] = TBL[e][50:35];
      q_j[1] = TBL[e][34]; q_t[1] = TBL[e][33:18];
      serve();
      chk(halted, "R11 halt after word", halted, 1);
      chk(fetch_pc == TBL[e][17:2], "R9/R4 next pc", fetch_pc, TBL[e][17:2]);
      chk(ndisp == int'(TBL[e][1:0]), "R4 dispatch count", ndisp, TBL[e][1:0]);
      case (w[31:30])
        2'b11: chk(lg_long[0] && lg_a[0] == w[29:0], "R1 long payload", lg_a[0], w[29:0]);
        2'b01: begin
          chk(!lg_right[0] && lg_a[0] == {15'd0, w[29:15]}, "R2 left first", lg_a[0], w[29:15]);
          if (ndisp == 2)
            chk(lg_right[1] && lg_a[1] == {15'd0, w[14:0]}, "R2 right second", lg_a[1], w[14:0]);
        end
        2'b10: begin
          chk(lg_right[0] && lg_a[0] == {15'd0, w[14:0]}, "R2 right first", lg_a[0], w[14:0]);
          if (ndisp == 2)
            chk(!lg_right[1] && lg_a[1] == {15'd0, w[29:15]}, "R2 left second", lg_a[1], w[29:15]);
        end
        default: chk(lg_par[0] && lg_a[0][14:0] == w[29:15] && lg_b[0] == w[14:0],
                     "R3 parallel pair", {lg_a[0][14:0], lg_b[0]}, w[29:0]);
      endcase
    end
    chk(cnt_jskip == 1, "R4 squash count", cnt_jskip, 1);
    chk(cnt_par == 1, "R7 parallel count", cnt_par, 1);
    chk(cnt_nop_l == 1 && cnt_nop_r == 0, "R7 nop sides", {cnt_nop_l[15:0], cnt_nop_r[15:0]}, 32'h0001_0000);

    // R8 repeat loop over words 0x20..0x21, two passes
    @(negedge clk);
    rpt_wr = 1; rpt_start = 16'h20; rpt_end = 16'h21; rpt_count = 16'd2;
    @(negedge clk); rpt_wr = 0;
    chk(rpt_active, "R8 armed", rpt_active, 1);
    long_word(1, 16'h20);
    chk(fetch_pc == 16'h20, "R9 jump target", fetch_pc, 16'h20);
    long_word(0, 0); chk(fetch_pc == 16'h21, "R8 inside loop", fetch_pc, 16'h21);
    long_word(0, 0); chk(fetch_pc == 16'h20, "R8 loop back", fetch_pc, 16'h20);
    chk(rpt_active, "R8 still active", rpt_active, 1);
    long_word(0, 0); chk(fetch_pc == 16'h21, "R8 second pass", fetch_pc, 16'h21);
    long_word(0, 0); chk(fetch_pc == 16'h22, "R8 exit falls through", fetch_pc, 16'h22);
    chk(!rpt_active, "R8 cleared", rpt_active, 0);

    chk(cnt_cycles == 15, "R5 cycles", cnt_cycles, 15);
    chk(cnt_lr == 2 && cnt_rl == 2 && cnt_long == 6, "R6 formats",
        {cnt_lr[7:0], cnt_rl[7:0], cnt_long[7:0]}, 24'h020206);

    // R11 free run, R10 exception on third word
    step_mode = 0;
    clear_q();
    for (int i = 0; i < 3; i++) q_word[i] = 32'hC0000001 + i;
    q_x[2] = 1;
    serve();
    chk(nfetch == 3, "R11 free run fetches", nfetch, 3);
    chk(exc_held && !halted, "R10 exception held", exc_held, 1);
    chk(fetch_pc == 16'h24, "R10 pc kept", fetch_pc, 16'h24);
    chk(cnt_cycles == 18 && cnt_long == 9, "R5 free run cycles", cnt_cycles, 18);
    @(negedge clk); go = 1;
    @(negedge clk); go = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (fetch_req || disp_vld || disp_par || !exc_held) begin
        chk(0, "R10 go ignored", {fetch_req, disp_vld, disp_par, exc_held}, 4'b0001);
        break;
      end
    end
    chk(exc_held && fetch_pc == 16'h24, "R10 still stopped", fetch_pc, 16'h24);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule